// File: doc/BRIEF.md
# Accelerometer Offset Calibration Engine

This block works out the three per-axis offset trim bytes of a three-axis accelerometer and writes them back. It assumes the sensor is held still with X and Y at 0 g and Z at +1 g. After a `start` pulse it waits a fixed settling time. It then sums a fixed number of full-resolution readings per axis and forms the average of each axis. Each average becomes a coarser correction code in 8-bit two's complement. On Z, the reading that +1 g produces (256 LSB at about 3.9 mg/LSB) is taken away first, so only the error is left.

The corrections are the negated quarter of each residual error, because one trim LSB is worth about four output LSBs (about 15.6 mg). The sensor adds the trim to what it measures. The engine issues three register writes through a request/acknowledge port, always in the order X, Y, Z. It then raises `done` and keeps the three trim bytes on its outputs. Orientation, the serial transport and any finer correction on the host side are left to the surrounding system.

The controller walks through six named states:
- IDLE: it waits for `start`.
- SETTLE: it times the settling wait. It moves to ACCUM when the timer expires.
- ACCUM: it adds every valid reading. It moves to CALC on the last sample of the batch.
- CALC: it registers the three trims in one cycle, then moves to WRITE.
- WRITE: it issues one write per axis and moves on with each acknowledge. After the third acknowledge it goes to DONE.
- DONE: it holds `done`. A new `start` sends it back to SETTLE.

Top module: `cal_offset_engine`

## Requirements
- R1: After reset, `done` and `wr_req` are low and `trim_x`, `trim_y`, `trim_z` are 0x00.
- R2: A `start` pulse in IDLE or DONE begins a settling wait of SETTLE_CYCLES clock cycles. Any `sample_valid` beat during that wait, or while idle, adds nothing to any sum.
- R3: After the wait, exactly NUM_SAMPLES beats with `sample_valid` high are summed per axis. Each axis reading is a signed SAMPLE_W-bit value.
- R4: The average of each axis is the sum divided by NUM_SAMPLES, truncated toward zero.
- R5: The X and Y trims equal the negation of the average shifted right arithmetically by two. This division by 4 rounds toward negative infinity.
- R6: The Z trim is formed the same way, but GRAV_REF (default 256) is subtracted from the Z average before the shift.
- R7: Every trim saturates to the signed range −128 (0x80) to +127 (0x7F).
- R8: The trims are written in a fixed order: X to address 0x1E, then Y to 0x1F, then Z to 0x20. `wr_req` stays high with `wr_addr` and `wr_data` unchanged until `wr_ack` is sampled high.
- R9: `done` rises in the cycle after the cycle in which the third `wr_ack` is sampled. It stays high, with the trims held on `trim_x`/`trim_y`/`trim_z`, until the next `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a calibration run when idle or done |
| sample_valid | input | 1 | A new three-axis reading is present |
| sample_x | input | SAMPLE_W | X reading, two's complement |
| sample_y | input | SAMPLE_W | Y reading, two's complement |
| sample_z | input | SAMPLE_W | Z reading, two's complement |
| wr_req | output | 1 | Register write request |
| wr_addr | output | 8 | Register address of the pending write |
| wr_data | output | 8 | Trim byte of the pending write |
| wr_ack | input | 1 | Write accepted |
| trim_x | output | 8 | Computed X trim |
| trim_y | output | 8 | Computed Y trim |
| trim_z | output | 8 | Computed Z trim |
| done | output | 1 | Calibration finished and all three trims written |

## Verification
The bench builds the engine with SETTLE_CYCLES at 20, so the settling window is short. A burst of out-of-range readings inside that window must leave the results unchanged. NUM_SAMPLES stays at its default of 100, so the sample sums are large enough to show both rounding rules: a sum of −450 has to give an average of −4, not −5, before the floor shift. The sample patterns drive the trims into both saturation limits and into the exact edge code −128. Acknowledges come back with varying delays, which tests the hold of the write port and the one-cycle gap before `done` rises.

// File: rtl/cal_pkg.sv
package cal_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_ACCUM,
        ST_CALC,
        ST_WRITE,
        ST_DONE
    } cal_state_t;

    localparam int TRIM_W = 8;
    localparam int NUM_AXES = 3;

endpackage

// File: rtl/cal_settle_timer.sv
module cal_settle_timer #(
    parameter int SETTLE_CYCLES = 1110000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || expired) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == LAST);
endmodule

// File: rtl/cal_axis_accum.sv
module cal_axis_accum #(
    parameter int SAMPLE_W = 16,
    parameter int SUM_W    = 23
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       en,
    input  logic signed [SAMPLE_W-1:0] sample,
    output logic signed [SUM_W-1:0]    sum
);
    logic signed [SUM_W-1:0] sample_ext;
    assign sample_ext = {{(SUM_W-SAMPLE_W){sample[SAMPLE_W-1]}}, sample};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum <= '0;
        end else if (clear) begin
            sum <= '0;
        end else if (en) begin
            sum <= sum + sample_ext;
        end
    end
endmodule

// File: rtl/cal_trim_calc.sv
module cal_trim_calc #(
    parameter int SUM_W       = 23,
    parameter int NUM_SAMPLES = 100,
    parameter int GRAV_SUB    = 0
) (
    input  logic signed [SUM_W-1:0] sum,
    output logic [7:0]              trim
);
    localparam int EW = SUM_W + 2;
    localparam logic signed [EW-1:0] DIVISOR = EW'(NUM_SAMPLES);
    localparam logic signed [EW-1:0] GREF    = EW'(GRAV_SUB);
    localparam logic signed [EW-1:0] MAXV    = EW'(127);
    localparam logic signed [EW-1:0] MINV    = -EW'(128);

    logic signed [EW-1:0] sum_ext, avg, resid, quart, neg;

    always_comb begin
        sum_ext = {{2{sum[SUM_W-1]}}, sum};
        avg     = sum_ext / DIVISOR;
        resid   = avg - GREF;
        quart   = resid >>> 2;
        neg     = -quart;
        if (neg > MAXV) begin
            trim = 8'h7F;
        end else if (neg < MINV) begin
            trim = 8'h80;
        end else begin
            trim = neg[7:0];
        end
    end
endmodule

// File: rtl/cal_offset_engine.sv
module cal_offset_engine
    import cal_pkg::*;
#(
    parameter int         SETTLE_CYCLES = 1110000,
    parameter int         NUM_SAMPLES   = 100,
    parameter int         SAMPLE_W      = 16,
    parameter int         GRAV_REF      = 256,
    parameter logic [7:0] ADDR_X        = 8'h1E,
    parameter logic [7:0] ADDR_Y        = 8'h1F,
    parameter logic [7:0] ADDR_Z        = 8'h20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                sample_valid,
    input  logic [SAMPLE_W-1:0] sample_x,
    input  logic [SAMPLE_W-1:0] sample_y,
    input  logic [SAMPLE_W-1:0] sample_z,
    output logic                wr_req,
    output logic [7:0]          wr_addr,
    output logic [7:0]          wr_data,
    input  logic                wr_ack,
    output logic [7:0]          trim_x,
    output logic [7:0]          trim_y,
    output logic [7:0]          trim_z,
    output logic                done
);
    localparam int CNT_W = $clog2(NUM_SAMPLES + 1);
    localparam int SUM_W = SAMPLE_W + CNT_W;
    localparam logic [CNT_W-1:0] LAST_SAMPLE = CNT_W'(NUM_SAMPLES - 1);

    cal_state_t state, state_nx;
    logic [CNT_W-1:0] samp_cnt;
    logic [1:0]       wr_idx;
    logic             settle_done;
    logic             acc_en;
    logic             acc_clr;
    logic             go;

    logic [SAMPLE_W-1:0]     axis_in  [NUM_AXES];
    logic signed [SUM_W-1:0] axis_sum [NUM_AXES];
    logic [7:0]              axis_trim[NUM_AXES];

    assign axis_in[0] = sample_x;
    assign axis_in[1] = sample_y;
    assign axis_in[2] = sample_z;

    assign go      = start && (state == ST_IDLE || state == ST_DONE);
    assign acc_clr = go;
    assign acc_en  = (state == ST_ACCUM) && sample_valid;

    cal_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state == ST_SETTLE),
        .expired (settle_done)
    );

    for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
        cal_axis_accum #(.SAMPLE_W(SAMPLE_W), .SUM_W(SUM_W)) u_acc (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (acc_clr),
            .en     (acc_en),
            .sample (axis_in[a]),
            .sum    (axis_sum[a])
        );
        cal_trim_calc #(
            .SUM_W       (SUM_W),
            .NUM_SAMPLES (NUM_SAMPLES),
            .GRAV_SUB    ((a == 2) ? GRAV_REF : 0)
        ) u_calc (
            .sum  (axis_sum[a]),
            .trim (axis_trim[a])
        );
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_SETTLE;
            ST_SETTLE: if (settle_done) state_nx = ST_ACCUM;
            ST_ACCUM:  if (acc_en && samp_cnt == LAST_SAMPLE) state_nx = ST_CALC;
            ST_CALC:   state_nx = ST_WRITE;
            ST_WRITE:  if (wr_ack && wr_idx == 2'd2) state_nx = ST_DONE;
            ST_DONE:   if (start) state_nx = ST_SETTLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_cnt <= '0;
            wr_idx   <= '0;
            trim_x   <= '0;
            trim_y   <= '0;
            trim_z   <= '0;
        end else begin
            if (go) begin
                samp_cnt <= '0;
            end else if (acc_en) begin
                samp_cnt <= samp_cnt + 1'b1;
            end
            if (state == ST_CALC) begin
                trim_x <= axis_trim[0];
                trim_y <= axis_trim[1];
                trim_z <= axis_trim[2];
                wr_idx <= '0;
            end else if (state == ST_WRITE && wr_ack) begin
                wr_idx <= wr_idx + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        wr_req  = (state == ST_WRITE);
        done    = (state == ST_DONE);
        wr_addr = ADDR_X;
        wr_data = trim_x;
        unique case (wr_idx)
            2'd0:    begin wr_addr = ADDR_X; wr_data = trim_x; end
            2'd1:    begin wr_addr = ADDR_Y; wr_data = trim_y; end
            default: begin wr_addr = ADDR_Z; wr_data = trim_z; end
        endcase
    end
endmodule

// File: rtl/cal_offset_engine_chk.sv
module cal_offset_engine_chk #(
    parameter logic [7:0] ADDR_X = 8'h1E,
    parameter logic [7:0] ADDR_Y = 8'h1F,
    parameter logic [7:0] ADDR_Z = 8'h20
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_req,
    input logic       wr_ack,
    input logic [7:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       done
);
    // R8
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

    // R8
    wr_first_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_req) |-> (wr_addr == ADDR_X));

    // R8
    wr_addr_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (wr_addr == ADDR_X || wr_addr == ADDR_Y || wr_addr == ADDR_Z));

    // R9
    done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(wr_req && wr_ack && wr_addr == ADDR_Z));

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !wr_req);
endmodule

bind cal_offset_engine cal_offset_engine_chk #(
    .ADDR_X (ADDR_X),
    .ADDR_Y (ADDR_Y),
    .ADDR_Z (ADDR_Z)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_req  (wr_req),
    .wr_ack  (wr_ack),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .done    (done)
);

// File: tb/cal_offset_engine_tb.sv
module cal_offset_engine_tb;
    localparam int SETTLE = 20;
    localparam int NS     = 100;
    localparam int SW     = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          sample_valid = 1'b0;
    logic [SW-1:0] sample_x = '0, sample_y = '0, sample_z = '0;
    logic          wr_req;
    logic [7:0]    wr_addr, wr_data;
    logic          wr_ack = 1'b0;
    logic [7:0]    trim_x, trim_y, trim_z;
    logic          done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    cal_offset_engine #(
        .SETTLE_CYCLES (SETTLE),
        .NUM_SAMPLES   (NS),
        .SAMPLE_W      (SW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .sample_valid(sample_valid),
        .sample_x(sample_x), .sample_y(sample_y), .sample_z(sample_z),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
        .trim_x(trim_x), .trim_y(trim_y), .trim_z(trim_z), .done(done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_trim(input int first, input int base, input int gref);
        int sum, avg, r, q, n;
        sum = first + (NS - 1) * base;
        avg = sum / NS;
        r = avg - gref;
        q = (r - (((r % 4) + 4) % 4)) / 4;
        n = -q;
        if (n > 127) n = 127;
        if (n < -128) n = -128;
        return n[7:0];
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic write_phase(input logic [7:0] ex, input logic [7:0] ey, input logic [7:0] ez,
                               input int delay);
        logic [7:0] addrs [3];
        logic [7:0] datas [3];
        addrs[0] = 8'h1E; addrs[1] = 8'h1F; addrs[2] = 8'h20;
        datas[0] = ex; datas[1] = ey; datas[2] = ez;
        for (int k = 0; k < 3; k++) begin
            int guard = 0;
            while (!wr_req && guard < 50) begin step(); guard++; end
            check("R8 req", int'(wr_req), 1);
            check("R8 addr", int'(wr_addr), int'(addrs[k]));
            check("R8 data", int'(wr_data), int'(datas[k]));
            for (int d = 0; d < delay + k; d++) step();
            check("R8 hold addr", int'(wr_addr), int'(addrs[k]));
            check("R8 hold data", int'(wr_data), int'(datas[k]));
            check("R9 not early", int'(done), 0);
            wr_ack = 1'b1;
            step();
            wr_ack = 1'b0;
        end
        check("R9 done one cycle after ack", int'(done), 1);
        check("R9 trim_x", int'(trim_x), int'(ex));
        check("R9 trim_y", int'(trim_y), int'(ey));
        check("R9 trim_z", int'(trim_z), int'(ez));
        step(); step();
        check("R9 done held", int'(done), 1);
    endtask

    task automatic run_case(input string name,
                            input int fx, input int bx, input int fy, input int by,
                            input int fz, input int bz, input int delay);
        logic [7:0] ex, ey, ez;
        ex = model_trim(fx, bx, 0);
        ey = model_trim(fy, by, 0);
        ez = model_trim(fz, bz, 256);
        $display("case %s", name);
        // junk beat while idle/done: R2
        sample_valid = 1'b1; sample_x = 16'h7FFF; sample_y = 16'h8000; sample_z = 16'h7FFF;
        step();
        sample_valid = 1'b0;
        start = 1'b1;
        step();
        start = 1'b0;
        // junk beats during settling: R2
        for (int i = 0; i < SETTLE - 3; i++) begin
            sample_valid = 1'b1; sample_x = 16'h7FFF; sample_y = 16'h8000; sample_z = 16'h7FFF;
            step();
        end
        sample_valid = 1'b0;
        for (int i = 0; i < 6; i++) step();
        // R3 batch, with idle gaps between beats
        for (int i = 0; i < NS; i++) begin
            sample_valid = 1'b1;
            sample_x = SW'((i == 0) ? fx : bx);
            sample_y = SW'((i == 0) ? fy : by);
            sample_z = SW'((i == 0) ? fz : bz);
            step();
            if (i % 7 == 3) begin
                sample_valid = 1'b0;
                step();
            end
        end
        sample_valid = 1'b0;
        write_phase(ex, ey, ez, delay);
    endtask

    initial begin
        #1;
        for (int i = 0; i < 3; i++) step();
        // R1 reset state
        check("R1 done", int'(done), 0);
        check("R1 wr_req", int'(wr_req), 0);
        check("R1 trim_x", int'(trim_x), 0);
        check("R1 trim_y", int'(trim_y), 0);
        check("R1 trim_z", int'(trim_z), 0);
        rst_n = 1'b1;
        step();
        check("R1 idle after release", int'(wr_req), 0);

        // R5 R6 basic: 40 -> F6, -41 -> 0B, 276 -> FB
        run_case("R5_R6_basic", 40, 40, -41, -41, 276, 276, 0);
        // R4 truncation: -450 -> avg -4 -> trim 01; 450 -> FF; 25250 -> 252 -> 01
        run_case("R4_trunc", -450, 0, 450, 0, -94, 256, 2);
        // R7 saturation at both limits
        run_case("R7_sat", 2000, 2000, -2000, -2000, -4000, -4000, 1);
        // R7 edge: 508 -> 81, -512 -> 7F, 768 -> 80
        run_case("R7_edge", 508, 508, -512, -512, 768, 768, 3);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule